// File: doc/BRIEF.md
# Frame Phase Offset Meter

The block measures how far the received 8 kHz frame marker sits from the local serial-bus frame. It runs on the local 2.048 MHz bit clock and counts bit positions from the local frame pulse: 32 channels of 8 bits, so 256 positions per 125 µs frame. The marker comes from the receive clock domain. It is brought into the local domain by a two-stage synchronizer. On each of its rising edges the block captures the current position into an 8-bit phase word. The upper five bits of that word give the channel count and the lower three give the bit within the channel.

A ninth bit, the frame bit, extends the phase word across frame boundaries. It toggles whenever two consecutive captures differ by more than half a frame. Such a jump means the marker crossed the position 255/0 seam, in either direction. When the incoming data runs faster than the local clock, the readings fall over time. When it runs slower, they rise. Software or a clock-steering loop can follow the full nine-bit value to see a steady trend without seams.

Top module: `frame_phase_meter`

## Requirements
- R1: The bit-position counter is 0 after a clock edge at which `frame_pulse` is high. Otherwise it steps by one per clock and wraps from 255 to 0.
- R2: If `marker` is first seen high at clock edge E0, `phase_word` after edge E0+2 holds the position counter value from after edge E0+1. `phase_word` changes at no other time.
- R3: In `phase_word`, bits 7:3 carry the channel number and bits 2:0 carry the bit within the channel, so the word equals channel*8+bit.
- R4: A marker held high for many frames causes exactly one capture. Neither output changes again until the marker falls and rises once more.
- R5: When the previous capture exceeds the new one by more than 128 (a forward seam crossing), `frame_bit` toggles at that capture.
- R6: When the new capture exceeds the previous one by more than 128 (a backward seam crossing), `frame_bit` toggles at that capture.
- R7: When consecutive captures differ by 128 or less in either direction, including exactly 128, `frame_bit` keeps its value.
- R8: The first capture after reset never toggles `frame_bit`, whatever value it captures.
- R9: While reset is asserted and until the first capture, `phase_word` is 0 and `frame_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local 2.048 MHz bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | Local frame start, high for one clock |
| marker | input | 1 | Asynchronous 8 kHz receive frame marker |
| phase_word | output | 8 | Captured position: channel in bits 7:3, bit in bits 2:0 |
| frame_bit | output | 1 | Ninth phase bit, toggles on each seam crossing |

## Verification
The bench sweeps every one of the 256 capture positions, stepping forward and then backward. This catches a design with an off-by-one in synchronizer latency, which would report every value shifted by one, and a design that misses seam crossings in one direction. Differences of exactly 128 and 129 are placed deliberately. A design with the wrong strict/non-strict comparison would toggle at exactly half a frame or stay quiet at 129. Further tests hold the marker high across several frames, insert an early frame pulse, and reset in mid-run. These expose level-triggered capture, a counter that ignores realignment, and a frame bit that toggles on the first capture after reset.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        SLIP_NONE = 2'd0,
        SLIP_FWD  = 2'd1,
        SLIP_BACK = 2'd2
    } slip_e;

    // Classify the step between two captured positions.
    function automatic slip_e slip_classify(input int unsigned prev_pos,
                                            input int unsigned next_pos,
                                            input int unsigned half_len);
        if (prev_pos > next_pos && (prev_pos - next_pos) > half_len)
            return SLIP_FWD;
        if (next_pos > prev_pos && (next_pos - prev_pos) > half_len)
            return SLIP_BACK;
        return SLIP_NONE;
    endfunction

endpackage

// File: rtl/fpm_marker_sync.sv
module fpm_marker_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic marker_async,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], marker_async};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.last;

    // R4
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/fpm_pos_counter.sv
module fpm_pos_counter #(
    parameter int FRAME_LEN = 256,
    parameter int POS_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_pulse)
            st_d.pos = '0;
        else if (st_q.pos == LAST_POS)
            st_d.pos = '0;
        else
            st_d.pos = st_q.pos + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_o = st_q.pos;

    // R1
    pulse_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> pos_o == '0);

    // R1
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse && pos_o != LAST_POS) |=> pos_o == POS_W'($past(pos_o) + 1'b1));

endmodule

// File: rtl/fpm_phase_capture.sv
module fpm_phase_capture
    import fpm_pkg::*;
#(
    parameter int FRAME_LEN = 256,
    parameter int POS_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [POS_W-1:0] pos_i,
    output logic [POS_W-1:0] phase_o,
    output logic             frame_bit_o
);
    localparam int unsigned HALF_LEN = FRAME_LEN / 2;

    typedef struct packed {
        logic [POS_W-1:0] phase;
        logic             fbit;
        logic             seen;
    } cap_st_t;

    cap_st_t st_d, st_q;
    slip_e   slip;

    always_comb begin
        st_d = st_q;
        slip = slip_classify(32'(st_q.phase), 32'(pos_i), HALF_LEN);
        if (capture) begin
            st_d.phase = pos_i;
            st_d.seen  = 1'b1;
            if (st_q.seen && slip != SLIP_NONE)
                st_d.fbit = ~st_q.fbit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o     = st_q.phase;
    assign frame_bit_o = st_q.fbit;

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(phase_o) && $stable(frame_bit_o)));

    // R2
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> phase_o == $past(pos_i));

    // R8
    first_no_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !st_q.seen) |=> $stable(frame_bit_o));

endmodule

// File: rtl/frame_phase_meter.sv
module frame_phase_meter #(
    parameter int CHANNELS    = 32,
    parameter int CH_BITS     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_pulse,
    input  logic       marker,
    output logic [$clog2(CHANNELS*CH_BITS)-1:0] phase_word,
    output logic       frame_bit
);
    localparam int FRAME_LEN = CHANNELS * CH_BITS;
    localparam int POS_W     = $clog2(FRAME_LEN);

    logic             marker_rise;
    logic [POS_W-1:0] bit_pos;

    fpm_marker_sync #(
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .marker_async(marker),
        .rise_o      (marker_rise)
    );

    fpm_pos_counter #(
        .FRAME_LEN(FRAME_LEN),
        .POS_W    (POS_W)
    ) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_pulse(frame_pulse),
        .pos_o      (bit_pos)
    );

    fpm_phase_capture #(
        .FRAME_LEN(FRAME_LEN),
        .POS_W    (POS_W)
    ) cap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (marker_rise),
        .pos_i      (bit_pos),
        .phase_o    (phase_word),
        .frame_bit_o(frame_bit)
    );

    // R9
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (phase_word == '0 && frame_bit == 1'b0));

endmodule

// File: tb/frame_phase_meter_tb_top.sv
module frame_phase_meter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fp = 1'b0;
    logic       marker = 1'b0;
    logic       force_req = 1'b0;
    logic [7:0] phase_word;
    logic       frame_bit;

    int ref_pos = 0;
    int tests = 0;
    int fails = 0;
    int exp_phase = 0;
    bit exp_fbit = 1'b0;
    bit has_prev = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frame_phase_meter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_pulse(fp),
        .marker     (marker),
        .phase_word (phase_word),
        .frame_bit  (frame_bit)
    );

    // Bench model of the bit position (R1)
    always @(posedge clk) begin
        if (!rst_n)  ref_pos <= 0;
        else if (fp) ref_pos <= 0;
        else         ref_pos <= (ref_pos + 1) % 256;
    end

    always @(negedge clk) fp <= rst_n && ((ref_pos == 255) || force_req);

    task automatic check(string req, int actual, int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic bit seam(int o, int n);
        return (o > n && (o - n) > 128) || (n > o && (n - o) > 128);
    endfunction

    task automatic measure(int t, int hold, string req);
        do @(negedge clk); while (ref_pos != ((t + 254) % 256));
        marker = 1'b1;
        repeat (3) @(negedge clk);
        if (has_prev && seam(exp_phase, t)) exp_fbit = ~exp_fbit;
        exp_phase = t;
        has_prev  = 1'b1;
        check({req, " phase"}, int'(phase_word), t);
        check({req, " frame bit"}, int'(frame_bit), int'(exp_fbit));
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            check("R4 held phase", int'(phase_word), t);
            check("R4 held frame bit", int'(frame_bit), int'(exp_fbit));
        end
        marker = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic inject_fp();
        @(posedge clk); #1 force_req = 1'b1;
        @(posedge clk); #1 force_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset phase", int'(phase_word), 0);
        check("R9 reset frame bit", int'(frame_bit), 0);
        rst_n = 1'b1;
        has_prev = 1'b0;
        exp_phase = 0;
        exp_fbit = 1'b0;
        repeat (20) @(negedge clk);
        check("R9 idle phase", int'(phase_word), 0);
        check("R9 idle frame bit", int'(frame_bit), 0);
    endtask

    initial begin
        int t;
        do_reset();

        // R8: first capture far from 0 must not toggle
        measure(200, 0, "R8 first capture");
        // R3: channel 17 bit 5
        measure(141, 0, "R3 split");
        check("R3 channel field", int'(phase_word[7:3]), 17);
        check("R3 bit field", int'(phase_word[2:0]), 5);

        // R2 R5: forward sweep covering all positions
        t = 141;
        for (int i = 0; i < 256; i++) begin
            t = (t + 9) % 256;
            measure(t, 0, "R2 R5 forward sweep");
        end

        // R6: backward sweep
        for (int i = 0; i < 64; i++) begin
            t = (t + 247) % 256;
            measure(t, 0, "R6 backward sweep");
        end

        // R7 R5 R6: half-frame boundaries
        measure(10, 0, "R7 base");
        measure(138, 0, "R7 diff +128");
        measure(10, 0, "R7 diff -128");
        measure(139, 0, "R6 diff +129");
        measure(10, 0, "R5 diff -129");

        // R4: marker held high across several frames
        measure(77, 600, "R4 hold");

        // R1: early frame pulse realigns the counter
        repeat (37) @(negedge clk);
        inject_fp();
        measure(60, 0, "R1 realign");
        inject_fp();
        measure(250, 0, "R1 realign again");

        // R9 R8: reset mid-run, then first capture
        do_reset();
        measure(5, 0, "R8 after reset");
        measure(190, 0, "R6 after reset");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule